// File: doc/BRIEF.md
# Shared Address/Data Bus Register Slave

This block is the slave end of a synchronous bus whose address and data are carried on one set of shared lines, one after the other. A transfer opens with a single address cycle. In that cycle the master marks the shared lines as carrying an address and gives the transfer direction. The low address bits travel on the shared lines. The high address bits have dedicated lines of their own. The slave latches the full address and the direction. From the next cycle on, the same shared lines carry data: the slave either drives read data or samples write data.

A transfer may be a burst. Each cycle in which the master keeps its data-valid signal high is one beat, and the latched address advances by one after each beat. The carry runs from the low field into the high field. The first cycle with data-valid low ends the burst, and the slave then waits for a new address cycle. Behind the bus sits a small register file. Addresses past its last entry read as zero, and writes to them are dropped. The slave drives the shared lines only through an output-enable, and it raises that enable only in read beats.

Top module: `muxbus_slave`

## Requirements
- R1: After synchronous reset the slave is idle, `ad_oe` is 0, `ad_out` is 0, and every register reads 0.
- R2: `ad_oe` is 0 in every address cycle and whenever no transfer is open.
- R3: A cycle with `addr_strobe` high, while no beat is in progress, latches the address `{addr_hi, ad_in[LO_W-1:0]}` and the direction (`dir_rd`: 1 = read, 0 = write). The first data beat is the next cycle.
- R4: In a read beat `ad_oe` is 1 and `ad_out` holds the register at the current address, in that same cycle.
- R5: Only the low `LO_W` shared bits form the address in the address cycle. The upper shared bits are ignored, and the high address bits come from `addr_hi`.
- R6: After each beat the address increases by one, so a burst touches consecutive registers.
- R7: A cycle with `data_valid` low during a transfer ends it, and the slave returns to idle. A later `data_valid` with no address cycle writes nothing and leaves `ad_oe` at 0.
- R8: Addresses of `DEPTH` (24) and above read as 0, and writes to them change no register.
- R9: The burst increment carries from the low address field into the high field. For example, low 15 / high 0 is followed by low 0 / high 1, which is address 16.
- R10: In a write beat `ad_oe` stays 0, and the register takes `ad_in` at the end of that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strobe | input | 1 | Marks an address cycle on the shared lines |
| dir_rd | input | 1 | Direction, sampled in the address cycle: 1 read, 0 write |
| data_valid | input | 1 | Marks a data beat |
| addr_hi | input | HI_W (4) | Dedicated high address bits |
| ad_in | input | SHARED_W (16) | Shared lines as seen by the slave |
| ad_out | output | SHARED_W (16) | Read data driven onto the shared lines |
| ad_oe | output | 1 | Output enable for `ad_out` |

## Verification
An address cycle takes effect at the clock edge that closes it, so the first data beat is the next cycle. Read data and `ad_oe` follow from the latched address and `data_valid` without a register in between. They are therefore due in the beat cycle itself. A write lands at the edge that closes its beat and can be read back in any later transfer. The bench drives its inputs just after a falling edge and samples one time unit later, still before the next rising edge, so every read result is checked in the cycle of its beat. The register contents the bench expects come from its own model, which is updated only by the writes it issues.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    localparam int DEF_SHARED_W = 16;
    localparam int DEF_LO_W     = 4;
    localparam int DEF_HI_W     = 4;
    localparam int DEF_DEPTH    = 24;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DATA = 1'b1
    } bus_state_e;

    typedef struct packed {
        bus_state_e st;
        logic       rd;
    } phase_t;

    function automatic logic addr_hit(input int unsigned addr, input int unsigned depth);
        return addr < depth;
    endfunction

endpackage

// File: rtl/muxbus_phase_ctrl.sv
module muxbus_phase_ctrl
    import muxbus_pkg::*;
#(
    parameter int LO_W = DEF_LO_W,
    parameter int HI_W = DEF_HI_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 addr_strobe,
    input  logic                 dir_rd,
    input  logic                 data_valid,
    input  logic [LO_W-1:0]      addr_lo,
    input  logic [HI_W-1:0]      addr_hi,
    output phase_t               phase,
    output logic [LO_W+HI_W-1:0] cur_addr,
    output logic                 beat
);
    localparam int ADDR_W = LO_W + HI_W;

    logic take;

    assign beat = (phase.st == ST_DATA) && data_valid;
    assign take = addr_strobe && !beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= '{st: ST_IDLE, rd: 1'b0};
            cur_addr <= '0;
        end else if (take) begin
            phase    <= '{st: ST_DATA, rd: dir_rd};
            cur_addr <= {addr_hi, addr_lo};
        end else if (beat) begin
            cur_addr <= cur_addr + ADDR_W'(1);
        end else begin
            phase.st <= ST_IDLE;
        end
    end

    // R3: address latched from the dedicated and shared low bits
    assert_latch_addr_R3: assert property (@(posedge clk) disable iff (rst)
        take |=> (cur_addr == $past({addr_hi, addr_lo})) && (phase.st == ST_DATA));

    // R6: each beat advances the address by one
    assert_burst_incr_R6: assert property (@(posedge clk) disable iff (rst)
        beat |=> cur_addr == ADDR_W'($past(cur_addr) + ADDR_W'(1)));

    // R7: a beat-less cycle with no new address closes the transfer
    assert_burst_end_R7: assert property (@(posedge clk) disable iff (rst)
        (phase.st == ST_DATA && !data_valid && !addr_strobe) |=> phase.st == ST_IDLE);

endmodule

// File: rtl/muxbus_regfile.sv
module muxbus_regfile
    import muxbus_pkg::*;
#(
    parameter int DATA_W = DEF_SHARED_W,
    parameter int ADDR_W = DEF_LO_W + DEF_HI_W,
    parameter int DEPTH  = DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              hit;
    logic [IDX_W-1:0]  idx;

    assign hit   = addr_hit(int'(addr), DEPTH);
    assign idx   = IDX_W'(addr);
    assign rdata = hit ? mem[idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && hit) begin
            mem[idx] <= wdata;
        end
    end

endmodule

// File: rtl/muxbus_slave.sv
module muxbus_slave
    import muxbus_pkg::*;
#(
    parameter int SHARED_W = DEF_SHARED_W,
    parameter int LO_W     = DEF_LO_W,
    parameter int HI_W     = DEF_HI_W,
    parameter int DEPTH    = DEF_DEPTH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                addr_strobe,
    input  logic                dir_rd,
    input  logic                data_valid,
    input  logic [HI_W-1:0]     addr_hi,
    input  logic [SHARED_W-1:0] ad_in,
    output logic [SHARED_W-1:0] ad_out,
    output logic                ad_oe
);
    localparam int ADDR_W = LO_W + HI_W;

    phase_t            phase;
    logic [ADDR_W-1:0] cur_addr;
    logic              beat;
    logic              we;
    logic [SHARED_W-1:0] rdata;

    muxbus_phase_ctrl #(.LO_W(LO_W), .HI_W(HI_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .addr_strobe(addr_strobe),
        .dir_rd     (dir_rd),
        .data_valid (data_valid),
        .addr_lo    (ad_in[LO_W-1:0]),
        .addr_hi    (addr_hi),
        .phase      (phase),
        .cur_addr   (cur_addr),
        .beat       (beat)
    );

    assign we = beat && !phase.rd;

    muxbus_regfile #(.DATA_W(SHARED_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_regs (
        .clk  (clk),
        .rst  (rst),
        .we   (we),
        .addr (cur_addr),
        .wdata(ad_in),
        .rdata(rdata)
    );

    assign ad_oe  = beat && phase.rd;
    assign ad_out = ad_oe ? rdata : '0;

    // R2: no drive while idle (covers every address cycle taken from idle)
    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (phase.st == ST_IDLE) |-> !ad_oe);

    // R8: reads past the register file return zero
    assert_oob_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (ad_oe && int'(cur_addr) >= DEPTH) |-> ad_out == '0);

    // R10: write beats never drive the shared lines
    assert_write_no_drive_R10: assert property (@(posedge clk) disable iff (rst)
        (phase.st == ST_DATA && !phase.rd) |-> !ad_oe);

endmodule

// File: tb/muxbus_slave_bench.sv
module muxbus_slave_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        addr_strobe, dir_rd, data_valid;
    logic [3:0]  addr_hi;
    logic [15:0] ad_in, ad_out;
    logic        ad_oe;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    muxbus_slave u_muxbus_slave (
        .clk(clk), .rst(rst), .addr_strobe(addr_strobe), .dir_rd(dir_rd),
        .data_valid(data_valid), .addr_hi(addr_hi), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic addr_phase(input logic [3:0] hi, input logic [15:0] shared, input logic rd);
        addr_strobe = 1'b1; dir_rd = rd; addr_hi = hi; ad_in = shared; data_valid = 1'b0;
        #1 check("R2 oe in address cycle", {15'd0, ad_oe}, 16'd0);
        cyc();
        addr_strobe = 1'b0; addr_hi = 4'hA;
    endtask

    task automatic wbeat(input logic [15:0] d);
        data_valid = 1'b1; ad_in = d;
        #1 check("R10 oe in write beat", {15'd0, ad_oe}, 16'd0);
        cyc();
    endtask

    task automatic rbeat(input string req, input logic [15:0] exp);
        data_valid = 1'b1; ad_in = 16'h5A5A;
        #1;
        check({req, " oe"}, {15'd0, ad_oe}, 16'd1);
        check({req, " data"}, ad_out, exp);
        cyc();
    endtask

    task automatic end_xfer();
        data_valid = 1'b0; ad_in = 16'h0;
        cyc();
    endtask

    task automatic t_reset();
        rst = 1'b1; addr_strobe = 1'b0; dir_rd = 1'b0; data_valid = 1'b0;
        addr_hi = 4'h0; ad_in = 16'h0;
        repeat (3) cyc();
        rst = 1'b0;
        #1;
        check("R1 oe after reset", {15'd0, ad_oe}, 16'd0);
        check("R1 out after reset", ad_out, 16'd0);
        cyc();
        addr_phase(4'h0, 16'h0003, 1'b1); rbeat("R1 reg3 after reset", 16'h0); end_xfer();
    endtask

    task automatic t_single();
        addr_phase(4'h0, 16'hAB05, 1'b0); wbeat(16'h1234); end_xfer();
        addr_phase(4'h0, 16'h0005, 1'b1); rbeat("R3 R4 R5 single read", 16'h1234); end_xfer();
    endtask

    task automatic t_split();
        addr_phase(4'h1, 16'hF002, 1'b0); wbeat(16'hBEEF); end_xfer();
        addr_phase(4'h1, 16'h0002, 1'b1); rbeat("R5 high bits from addr_hi", 16'hBEEF); end_xfer();
        addr_phase(4'h0, 16'h0002, 1'b1); rbeat("R5 other high value", 16'h0000); end_xfer();
    endtask

    task automatic t_burst();
        addr_phase(4'h0, 16'h0008, 1'b0);
        for (int i = 0; i < 4; i++) wbeat(16'h1000 + 16'(i));
        end_xfer();
        addr_phase(4'h0, 16'h0008, 1'b1);
        for (int i = 0; i < 4; i++) rbeat("R6 burst read", 16'h1000 + 16'(i));
        end_xfer();
        addr_phase(4'h0, 16'h000A, 1'b1);
        rbeat("R6 burst mid start", 16'h1002);
        rbeat("R6 burst mid next", 16'h1003);
        end_xfer();
    endtask

    task automatic t_end();
        addr_phase(4'h0, 16'h0008, 1'b0); wbeat(16'h2222); end_xfer();
        data_valid = 1'b1; ad_in = 16'hDEAD;
        #1 check("R7 oe on stray beat", {15'd0, ad_oe}, 16'd0);
        cyc();
        end_xfer();
        addr_phase(4'h0, 16'h0008, 1'b1);
        rbeat("R7 reg8 after end", 16'h2222);
        rbeat("R7 reg9 untouched", 16'h1001);
        end_xfer();
    endtask

    task automatic t_oob();
        addr_phase(4'h1, 16'h000D, 1'b0); wbeat(16'h7777); end_xfer();
        addr_phase(4'h1, 16'h000D, 1'b1); rbeat("R8 read addr 29", 16'h0000); end_xfer();
        addr_phase(4'h0, 16'h0005, 1'b1); rbeat("R8 alias reg5 unchanged", 16'h1234); end_xfer();
        addr_phase(4'hF, 16'h000F, 1'b1); rbeat("R8 read addr 255", 16'h0000); end_xfer();
    endtask

    task automatic t_carry();
        addr_phase(4'h0, 16'h000F, 1'b0); wbeat(16'h3F3F); wbeat(16'h4040); end_xfer();
        addr_phase(4'h1, 16'h0000, 1'b1); rbeat("R9 carry into high field", 16'h4040); end_xfer();
        addr_phase(4'h0, 16'h000F, 1'b1); rbeat("R9 addr 15", 16'h3F3F); end_xfer();
        addr_phase(4'h1, 16'h0006, 1'b0); wbeat(16'h6666); wbeat(16'h7070); wbeat(16'h9999); end_xfer();
        addr_phase(4'h1, 16'h0006, 1'b1);
        rbeat("R9 addr 22", 16'h6666);
        rbeat("R9 addr 23", 16'h7070);
        rbeat("R8 R9 burst past end", 16'h0000);
        end_xfer();
    endtask

    initial begin
        t_reset();
        t_single();
        t_split();
        t_burst();
        t_end();
        t_oob();
        t_carry();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule